// File: doc/BRIEF.md
# Burst-of-Four Quad-Rate SRAM Model

A synthesizable behavioural model of a pipelined static memory with a dedicated read data path and a dedicated write data path that share a single address input. The model runs on one beat clock at twice the command rate. Beats alternate between a positive-phase beat, on which a read command and its address are taken, and a negative-phase beat, on which a write command and its address are taken. Every command moves a burst of four consecutive words, one word per beat, so each port moves two words per command cycle.

A write command is followed on the next four beats by its four data words, each with one active-low lane mask bit per byte lane. A read command produces its four words on the output three beats later, marked by a valid flag and a strobe that flips on every valid beat. The data output reads as zero whenever it is not valid, which stands in for a released bus. A read always sees every write whose command came before it, even when that write's data is still arriving. A command that lands in the second cycle of its own port's burst is dropped and raises a one-beat error flag.

Top module: `qdr_b4_sram`

## Requirements
- R1: While reset is asserted, and right after it, `rd_valid`, `rd_strobe`, `rd_cmd_err`, `wr_cmd_err` and `beat_odd` are 0 and `rd_data` is zero. The first clock edge after reset is a positive-phase beat. The memory contents are not defined by reset.
- R2: `beat_odd` flips on every clock edge after reset. It is 1 exactly when the coming edge is a negative-phase beat, so after edge e (counted from 0 after reset) it equals 1 when e is even.
- R3: `rd_sel_n` low on a positive-phase edge n starts a read of burst address `addr`. Word k (k = 0..3) comes from word address `addr*4+k` and is on `rd_data`, with `rd_valid` high, in the beat after edge n+3+k.
- R4: `wr_sel_n` low on a negative-phase edge t starts a write to burst address `addr`. Word k is taken from `wr_data` at edge t+1+k and stored at word address `addr*4+k`.
- R5: During a write word, `wr_lane_n[j]` = 1 leaves bits [8j+7:8j] of that word unchanged. `wr_lane_n[j]` = 0 stores them.
- R6: A read returns, for each word, the data of every write whose command edge came before the read's command edge, lane masks included. A write issued one beat earlier counts. A write issued one beat later does not.
- R7: `rd_data` is zero in every beat where `rd_valid` is 0.
- R8: `rd_strobe` flips in every beat where `rd_valid` is 1 and holds its value otherwise.
- R9: `rd_sel_n` on a negative-phase edge and `wr_sel_n` on a positive-phase edge have no effect and raise no error.
- R10: A select of a port on that port's edge two beats after one of its own accepted commands is dropped. A dropped read raises `rd_cmd_err` for the next beat only. A dropped write raises `wr_cmd_err` for the next beat only.
- R11: Read commands four beats apart give an unbroken run of valid words. Releasing the select after a command does not shorten that command's burst.
- R12: The read and write ports work at the same time without disturbing each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Beat clock, two beats per command cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_sel_n | input | 1 | Read command select, active low, used on positive-phase beats |
| wr_sel_n | input | 1 | Write command select, active low, used on negative-phase beats |
| addr | input | ADDR_W | Shared burst address |
| wr_data | input | WORD_W | Write data word for the current beat |
| wr_lane_n | input | LANES | Active-low lane write mask for the current beat |
| rd_data | output | WORD_W | Read data word, zero when not valid |
| rd_valid | output | 1 | Read data valid for this beat |
| rd_strobe | output | 1 | Flips on each valid read beat |
| beat_odd | output | 1 | High when the next edge is a negative-phase beat |
| rd_cmd_err | output | 1 | One-beat flag: a read command was dropped |
| wr_cmd_err | output | 1 | One-beat flag: a write command was dropped |

## Verification
The bench builds the model with ADDR_W = 3 and 16-bit words in two 8-bit lanes. That gives eight bursts of four words, so every location is written and read back while the other port is busy, and all four lane-mask combinations fit inside single bursts. The small size leaves room to place read and write commands one beat before and one beat after each other on the same address, which covers both directions of the ordering rule. It also leaves room for dropped commands, commands on the wrong phase and back-to-back read bursts. Expected outputs for every beat come from a separate array model that applies each accepted write in full at its command edge.

// File: rtl/qdr_pkg.sv
package qdr_pkg;

    // Words moved by one command on either port
    localparam int BURST_LEN  = 4;
    localparam int BEAT_IDX_W = $clog2(BURST_LEN);

    // Beat phase: positive-phase beats take reads, negative-phase beats take writes
    typedef enum logic {
        BEAT_POS = 1'b0,
        BEAT_NEG = 1'b1
    } beat_e;

endpackage

// File: rtl/qdr_burst_seq.sv
// Per-port command sequencer: accepts a command on its own beat phase,
// then walks the four word indices of the burst, one per beat.
module qdr_burst_seq
    import qdr_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         sample_en,
    input  logic                         sel_n,
    input  logic [ADDR_W-1:0]            cmd_addr,
    output logic                         accept,
    output logic                         step,
    output logic [ADDR_W+BEAT_IDX_W-1:0] word_addr,
    output logic                         cmd_err
);

    localparam logic [BEAT_IDX_W-1:0] LAST_IDX = BEAT_IDX_W'(BURST_LEN - 1);

    typedef struct packed {
        logic                  act;
        logic [BEAT_IDX_W-1:0] idx;
        logic [ADDR_W-1:0]     base;
        logic                  err;
    } seq_t;

    seq_t s_d, s_q;
    logic req, busy, take;

    always_comb begin
        s_d  = s_q;
        req  = sample_en && !sel_n;
        // A new command may only land on the beat that carries the final word
        busy = s_q.act && (s_q.idx != LAST_IDX);
        take = req && !busy;

        s_d.err = req && busy;

        if (s_q.act) begin
            s_d.idx = s_q.idx + 1'b1;
            if (s_q.idx == LAST_IDX) begin
                s_d.act = 1'b0;
            end
        end

        if (take) begin
            s_d.act  = 1'b1;
            s_d.idx  = '0;
            s_d.base = cmd_addr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign accept    = take;
    assign step      = s_q.act;
    assign word_addr = {s_q.base, s_q.idx};
    assign cmd_err   = s_q.err;

endmodule

// File: rtl/qdr_store.sv
// Word storage split into byte lanes, each lane its own array so that
// masked lane writes never share a storage element.
module qdr_store #(
    parameter int WADDR_W = 8,
    parameter int WORD_W  = 16,
    parameter int LANES   = 2
) (
    input  logic               clk,
    input  logic               wr_en,
    input  logic [WADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0]  wr_data,
    input  logic [LANES-1:0]   wr_lane_n,
    input  logic [WADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0]  rd_data
);

    localparam int LANE_W = WORD_W / LANES;
    localparam int DEPTH  = 1 << WADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] lane_mem [DEPTH];

        always_ff @(posedge clk) begin
            if (wr_en && !wr_lane_n[g]) begin
                lane_mem[wr_addr] <= wr_data[g*LANE_W +: LANE_W];
            end
        end

        assign rd_data[g*LANE_W +: LANE_W] = lane_mem[rd_addr];
    end

endmodule

// File: rtl/qdr_rd_pipe.sv
// Read return path: fetch stage, alignment stage, output stage.
module qdr_rd_pipe #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fetch_en,
    input  logic [WORD_W-1:0] fetch_data,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_data,
    output logic              out_strobe
);

    typedef struct packed {
        logic              f_v;
        logic [WORD_W-1:0] f_d;
        logic              a_v;
        logic [WORD_W-1:0] a_d;
        logic              o_v;
        logic [WORD_W-1:0] o_d;
        logic              o_s;
    } pipe_t;

    pipe_t p_d, p_q;

    always_comb begin
        p_d     = p_q;
        p_d.f_v = fetch_en;
        p_d.f_d = fetch_en ? fetch_data : '0;
        p_d.a_v = p_q.f_v;
        p_d.a_d = p_q.f_d;
        p_d.o_v = p_q.a_v;
        p_d.o_d = p_q.a_v ? p_q.a_d : '0;
        p_d.o_s = p_q.o_s ^ p_q.a_v;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p_q <= '0;
        end else begin
            p_q <= p_d;
        end
    end

    assign out_valid  = p_q.o_v;
    assign out_data   = p_q.o_d;
    assign out_strobe = p_q.o_s;

endmodule

// File: rtl/qdr_b4_sram.sv
// Burst-of-four separate-I/O SRAM model on a single beat clock.
module qdr_b4_sram
    import qdr_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int WORD_W = 16,
    parameter int LANES  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_sel_n,
    input  logic              wr_sel_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [LANES-1:0]  wr_lane_n,
    output logic [WORD_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              rd_strobe,
    output logic              beat_odd,
    output logic              rd_cmd_err,
    output logic              wr_cmd_err
);

    localparam int WADDR_W = ADDR_W + BEAT_IDX_W;

    beat_e phase_d, phase_q;

    logic               rd_accept, wr_accept;
    logic               rd_step, wr_step;
    logic [WADDR_W-1:0] rd_word, wr_word;
    logic [WORD_W-1:0]  fetch_data;

    always_comb begin
        phase_d = (phase_q == BEAT_POS) ? BEAT_NEG : BEAT_POS;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= BEAT_POS;
        end else begin
            phase_q <= phase_d;
        end
    end

    assign beat_odd = (phase_q == BEAT_NEG);

    qdr_burst_seq #(.ADDR_W(ADDR_W)) u_rd_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .sample_en (phase_q == BEAT_POS),
        .sel_n     (rd_sel_n),
        .cmd_addr  (addr),
        .accept    (rd_accept),
        .step      (rd_step),
        .word_addr (rd_word),
        .cmd_err   (rd_cmd_err)
    );

    qdr_burst_seq #(.ADDR_W(ADDR_W)) u_wr_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .sample_en (phase_q == BEAT_NEG),
        .sel_n     (wr_sel_n),
        .cmd_addr  (addr),
        .accept    (wr_accept),
        .step      (wr_step),
        .word_addr (wr_word),
        .cmd_err   (wr_cmd_err)
    );

    // Write words land on the edge they arrive; read words are fetched on the
    // beat after their slot opens, so earlier writes are always already stored.
    qdr_store #(
        .WADDR_W (WADDR_W),
        .WORD_W  (WORD_W),
        .LANES   (LANES)
    ) u_store (
        .clk       (clk),
        .wr_en     (wr_step),
        .wr_addr   (wr_word),
        .wr_data   (wr_data),
        .wr_lane_n (wr_lane_n),
        .rd_addr   (rd_word),
        .rd_data   (fetch_data)
    );

    qdr_rd_pipe #(.WORD_W(WORD_W)) u_rd_pipe (
        .clk        (clk),
        .rst_n      (rst_n),
        .fetch_en   (rd_step),
        .fetch_data (fetch_data),
        .out_valid  (rd_valid),
        .out_data   (rd_data),
        .out_strobe (rd_strobe)
    );

endmodule

// File: rtl/qdr_b4_sram_chk.sv
module qdr_b4_sram_chk #(
    parameter int WORD_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_sel_n,
    input logic              wr_sel_n,
    input logic              beat_odd,
    input logic [WORD_W-1:0] rd_data,
    input logic              rd_valid,
    input logic              rd_strobe,
    input logic              rd_cmd_err,
    input logic              wr_cmd_err,
    input logic              rd_accept,
    input logic              wr_accept
);

    // R3
    rd_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_accept |-> ##4 rd_valid);

    // R3
    rd_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_accept |-> !beat_odd);

    // R4
    wr_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_accept |-> beat_odd);

    // R7
    idle_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |-> (rd_data == '0));

    // R8
    strobe_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (rd_strobe != $past(rd_strobe)));

    // R8
    strobe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |-> $stable(rd_strobe));

    // R10
    rd_err_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_cmd_err |-> (beat_odd && $past(!rd_sel_n)));

    // R10
    wr_err_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cmd_err |-> (!beat_odd && $past(!wr_sel_n)));

    // R2
    beat_alt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (beat_odd != $past(beat_odd)));

endmodule

bind qdr_b4_sram qdr_b4_sram_chk #(.WORD_W(WORD_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_sel_n   (rd_sel_n),
    .wr_sel_n   (wr_sel_n),
    .beat_odd   (beat_odd),
    .rd_data    (rd_data),
    .rd_valid   (rd_valid),
    .rd_strobe  (rd_strobe),
    .rd_cmd_err (rd_cmd_err),
    .wr_cmd_err (wr_cmd_err),
    .rd_accept  (rd_accept),
    .wr_accept  (wr_accept)
);

// File: tb/sim_qdr_b4_sram.sv
module sim_qdr_b4_sram;

    localparam int AW    = 3;
    localparam int WW    = 16;
    localparam int LN    = 2;
    localparam int LW    = WW / LN;
    localparam int NE    = 256;
    localparam int RUN_E = 170;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rd_sel_n = 1'b1;
    logic          wr_sel_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [WW-1:0] wr_data = '0;
    logic [LN-1:0] wr_lane_n = '1;
    logic [WW-1:0] rd_data;
    logic          rd_valid, rd_strobe, beat_odd, rd_cmd_err, wr_cmd_err;

    always #5 clk = ~clk;

    qdr_b4_sram #(.ADDR_W(AW), .WORD_W(WW), .LANES(LN)) u0 (
        .clk(clk), .rst_n(rst_n), .rd_sel_n(rd_sel_n), .wr_sel_n(wr_sel_n),
        .addr(addr), .wr_data(wr_data), .wr_lane_n(wr_lane_n),
        .rd_data(rd_data), .rd_valid(rd_valid), .rd_strobe(rd_strobe),
        .beat_odd(beat_odd), .rd_cmd_err(rd_cmd_err), .wr_cmd_err(wr_cmd_err)
    );

    // Stimulus schedule, indexed by edge number after reset
    bit            s_rd [NE];
    bit            s_wr [NE];
    logic [AW-1:0] s_addr [NE];
    logic [WW-1:0] s_wd [NE];
    logic [LN-1:0] s_bw [NE];
    string         s_tag [NE];

    // Expected outputs after each edge
    bit            x_val [NE];
    logic [WW-1:0] x_dat [NE];
    bit            x_rerr [NE];
    bit            x_werr [NE];
    string         x_tag [NE];

    logic [WW-1:0] ref_mem [4 << AW];

    int  n_chk = 0;
    int  n_fail = 0;
    int  bn = 0;
    bit  sp = 1'b0;
    bit  done = 1'b0;

    function automatic logic [WW-1:0] wd(int a, int k, int salt);
        int v;
        v = (a * 37 + k * 11 + salt * 101) * 403 + 23;
        return WW'(v ^ 'h5a3c);
    endfunction

    task automatic chk(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h (edge %0d)", tag, what, act, exp, bn - 1);
        end
    endtask

    // mode 0: all lanes, 1: lane mask = k, 2: lane mask = 3-k
    task automatic sch_wr(int t, int a, int salt, int mode);
        s_wr[t]   = 1'b1;
        s_addr[t] = AW'(a);
        for (int k = 0; k < 4; k++) begin
            s_wd[t+1+k] = wd(a, k, salt);
            s_bw[t+1+k] = (mode == 0) ? LN'(0) : (mode == 1) ? LN'(k) : LN'(3 - k);
        end
    endtask

    task automatic sch_cmd_wr(int t, int a);
        s_wr[t]   = 1'b1;
        s_addr[t] = AW'(a);
    endtask

    task automatic sch_rd(int t, int a, string tag);
        s_rd[t]   = 1'b1;
        s_addr[t] = AW'(a);
        s_tag[t]  = tag;
    endtask

    task automatic build;
        int last_r, last_w;
        for (int e = 0; e < NE; e++) begin
            s_rd[e] = 1'b0; s_wr[e] = 1'b0;
            s_addr[e] = AW'(e); s_wd[e] = WW'(e * 'h1111); s_bw[e] = '0;
            s_tag[e] = "R3";
            x_val[e] = 1'b0; x_dat[e] = '0; x_rerr[e] = 1'b0; x_werr[e] = 1'b0;
            x_tag[e] = "R7";
        end
        // Fill all bursts while reading back the previous one (R4, R12, R3)
        for (int i = 0; i < 8; i++) sch_wr(1 + 4 * i, i, 1, 0);
        for (int i = 1; i <= 8; i++) sch_rd(4 * i, i - 1, (i <= 2) ? "R3" : (i <= 5) ? "R4" : "R12");
        // Read one beat after a write to the same burst sees it (R6)
        sch_wr(41, 2, 2, 0);
        sch_rd(42, 2, "R6");
        // Read one beat before a write does not see it (R6)
        sch_rd(50, 3, "R6");
        sch_wr(51, 3, 3, 0);
        sch_rd(56, 3, "R6");
        // Lane masks over every combination (R5)
        sch_wr(61, 4, 4, 1);
        sch_wr(65, 5, 4, 2);
        sch_rd(70, 4, "R5");
        sch_rd(74, 5, "R5");
        // Commands in the busy window are dropped (R10)
        sch_rd(80, 6, "R10");
        sch_rd(82, 7, "R10");
        sch_wr(85, 6, 5, 0);
        sch_cmd_wr(87, 7);
        sch_rd(92, 7, "R10");
        sch_rd(96, 6, "R10");
        // Wrong-phase selects (R9)
        sch_rd(101, 0, "R9");
        sch_cmd_wr(104, 0);
        sch_rd(112, 0, "R9");
        // Back-to-back reads with concurrent write (R11)
        sch_rd(120, 1, "R11");
        sch_wr(121, 7, 7, 0);
        sch_rd(124, 2, "R11");
        sch_rd(128, 3, "R11");

        last_r = -100;
        last_w = -100;
        for (int e = 0; e + 8 < NE; e++) begin
            if (s_rd[e]) begin
                if (e % 2 == 0) begin
                    if (e == last_r + 2) begin
                        x_rerr[e] = 1'b1;
                    end else begin
                        last_r = e;
                        for (int k = 0; k < 4; k++) begin
                            x_val[e+3+k] = 1'b1;
                            x_dat[e+3+k] = ref_mem[s_addr[e] * 4 + k];
                            x_tag[e+3+k] = s_tag[e];
                        end
                    end
                end else begin
                    for (int k = 0; k < 4; k++) if (!x_val[e+3+k]) x_tag[e+3+k] = "R9";
                end
            end
            if (s_wr[e] && (e % 2 == 1)) begin
                if (e == last_w + 2) begin
                    x_werr[e] = 1'b1;
                end else begin
                    last_w = e;
                    for (int k = 0; k < 4; k++)
                        for (int l = 0; l < LN; l++)
                            if (!s_bw[e+1+k][l])
                                ref_mem[s_addr[e] * 4 + k][l*LW +: LW] = s_wd[e+1+k][l*LW +: LW];
                end
            end
        end
    endtask

    always @(posedge clk) if (rst_n) bn <= bn + 1;

    // Compare the results of the last edge, then drive the next edge's inputs
    always @(negedge clk) begin
        if (rst_n && bn > 0 && bn <= RUN_E && !done) begin
            int e;
            e = bn - 1;
            chk(rd_valid === x_val[e], x_tag[e], "rd_valid", 32'(rd_valid), 32'(x_val[e]));
            if (x_val[e])
                chk(rd_data === x_dat[e], x_tag[e], "rd_data", 32'(rd_data), 32'(x_dat[e]));
            else
                chk(rd_data === '0, "R7", "idle rd_data", 32'(rd_data), 0);
            if (x_val[e]) sp = ~sp;
            chk(rd_strobe === sp, "R8", "rd_strobe", 32'(rd_strobe), 32'(sp));
            chk(rd_cmd_err === x_rerr[e], "R10", "rd_cmd_err", 32'(rd_cmd_err), 32'(x_rerr[e]));
            chk(wr_cmd_err === x_werr[e], "R10", "wr_cmd_err", 32'(wr_cmd_err), 32'(x_werr[e]));
            chk(beat_odd === (e % 2 == 0), "R2", "beat_odd", 32'(beat_odd), 32'(e % 2 == 0));
        end
        if (bn < NE) begin
            rd_sel_n  = !s_rd[bn];
            wr_sel_n  = !s_wr[bn];
            addr      = s_addr[bn];
            wr_data   = s_wd[bn];
            wr_lane_n = s_bw[bn];
        end
    end

    initial begin
        build();
        repeat (3) @(negedge clk);
        chk(rd_valid === 1'b0, "R1", "reset rd_valid", 32'(rd_valid), 0);
        chk(rd_data === '0, "R1", "reset rd_data", 32'(rd_data), 0);
        chk(rd_strobe === 1'b0, "R1", "reset rd_strobe", 32'(rd_strobe), 0);
        chk(rd_cmd_err === 1'b0 && wr_cmd_err === 1'b0, "R1", "reset errors",
            32'({rd_cmd_err, wr_cmd_err}), 0);
        chk(beat_odd === 1'b0, "R1", "reset beat_odd", 32'(beat_odd), 0);
        rst_n = 1'b1;
        wait (bn >= RUN_E);
        @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL R3 watchdog: actual %0d edges expected %0d", bn, RUN_E);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule